// File: doc/BRIEF.md
# Biphase Serial Word Transmitter

This block takes one 16-bit payload and a word-kind flag over a valid/ready handshake and sends it as one fixed-length word on a command/response avionics multiplex bus. It builds the frame itself. First comes a three-bit-time sync waveform whose polarity depends on the word kind. Then come the 16 payload bits, most significant first. Last comes an odd parity bit. The payload and parity bits are Manchester II coded onto a differential pair of drive lines, and an output enable frames the transmission. A half-bit clock enable sets the timing. It is derived from the system clock by a parameterised divider. The default of 100 cycles at 200 MHz gives 1 Mbit/s.

A word is 40 half-bit slots long: 6 sync slots, 32 payload slots and 2 parity slots. When the line is quiet, the block raises `in_ready`. When a word is accepted it raises `busy` and ignores its inputs until the frame has ended. In the cycle after the last slot it pulses `done`, and in that same cycle it can accept the next word.

The controller has four states:
- `ST_IDLE`: lines quiet, ready high.
- `ST_SYNC`: six sync slots.
- `ST_DATA`: sixteen payload bits, two slots each.
- `ST_PARITY`: two parity slots.

There are four transitions:
- IDLE to SYNC on accept.
- SYNC to DATA on the tick that ends the sixth slot.
- DATA to PARITY on the tick that ends the second half of the last payload bit.
- PARITY to IDLE on the tick that ends the parity bit, which also sets `done`.

The caller lays out command payloads itself, upper bits first: a 5-bit terminal address, then a transmit/receive flag, then a 5-bit subaddress/mode field, then a 5-bit count/mode code field. The block treats all 16 bits alike.

Top module: `mbt_word_tx`

## Requirements
- R1: After reset and whenever no word is in flight, `line_hi`, `line_lo` and `line_en` are 0, `busy` is 0, `in_ready` is 1 and `done` is 0.
- R2: A word is accepted in a cycle where `in_valid` and `in_ready` are both 1. `busy` is 1 and `in_ready` is 0 from the next cycle until the frame ends. `in_valid`, `in_payload` and `in_is_data` have no effect on a frame in flight.
- R3: A frame lasts exactly 40 half-bit slots of `HALF_BIT_CYCLES` clock cycles each, starting the cycle after acceptance. The drive lines change only at slot boundaries, and `line_en` is 1 throughout the frame.
- R4: With `in_is_data`=0 (command/status), the sync drives 3 slots high and then 3 slots low. With `in_is_data`=1 (data), it drives 3 slots low and then 3 slots high.
- R5: Payload bits follow the sync, bit 15 first. Each bit takes two slots. A 1 is sent high then low, and a 0 is sent low then high.
- R6: The parity bit follows bit 0 in the same two-slot coding. Its value makes the count of ones over the 16 payload bits plus the parity bit odd.
- R7: While `line_en` is 1, `line_lo` is the complement of `line_hi`. The level named in R4 to R6 is the level on `line_hi`.
- R8: `done` is 1 for exactly one cycle, in the first cycle after the last slot. In that cycle `busy` is 0 and `in_ready` is 1, so a new word can be accepted back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can accept a word |
| in_payload | input | 16 | Payload, bit 15 sent first |
| in_is_data | input | 1 | 1 = data word sync, 0 = command/status sync |
| busy | output | 1 | A frame is in flight |
| done | output | 1 | One-cycle pulse after the frame |
| line_hi | output | 1 | Positive line drive |
| line_lo | output | 1 | Negative line drive |
| line_en | output | 1 | Line driver enable |

## Verification
Both word kinds are sent with mixed payloads, so the two sync polarities can be told apart against identical bit coding. The all-ones and all-zeros payloads separate a swapped Manchester phase from a swapped bit order, and they force the parity bit to 1. The single-bit payloads 16'h8000 and 16'h0001 expose a bit-order reversal and give even-parity cases where the parity bit is 0. One frame is sent while junk inputs are held valid, to show that inputs are ignored while busy. A back-to-back pair shows that a word is accepted in the `done` cycle.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_PARITY
    } tx_state_t;

    typedef enum logic {
        WT_CMD_STATUS = 1'b0,
        WT_DATA       = 1'b1
    } word_kind_t;

endpackage

// File: rtl/mbt_halfbit_tick.sv
module mbt_halfbit_tick #(
    parameter int HALF_BIT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_BIT_CYCLES > 1) ? $clog2(HALF_BIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_BIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mbt_parity_gen.sv
module mbt_parity_gen #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data,
    output logic              par_bit
);
    // odd parity over data plus this bit
    assign par_bit = ~(^data);
endmodule

// File: rtl/mbt_manchester.sv
module mbt_manchester (
    input  logic bit_val,
    input  logic second_half,
    output logic level
);
    // first half carries the bit, second half its complement
    assign level = second_half ? ~bit_val : bit_val;
endmodule

// File: rtl/mbt_word_tx.sv
module mbt_word_tx
    import mbt_pkg::*;
#(
    parameter int DATA_W          = 16,
    parameter int SYNC_HALVES     = 6,
    parameter int HALF_BIT_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_payload,
    input  logic              in_is_data,
    output logic              busy,
    output logic              done,
    output logic              line_hi,
    output logic              line_lo,
    output logic              line_en
);
    localparam int SYNC_SPLIT = SYNC_HALVES / 2;
    localparam int MAXCNT     = (SYNC_HALVES > DATA_W) ? SYNC_HALVES : DATA_W;
    localparam int CNT_W      = $clog2(MAXCNT);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_HALVES - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] SPLIT_CNT = CNT_W'(SYNC_SPLIT);

    tx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic              half_ph;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    word_kind_t        kind;
    logic              done_q;

    logic half_tick;
    logic par_calc;
    logic accept;
    logic tx_bit;
    logic coded_lvl;
    logic sync_lvl;
    logic run;

    assign run    = (state != ST_IDLE);
    assign accept = in_valid && (state == ST_IDLE);

    mbt_halfbit_tick #(.HALF_BIT_CYCLES(HALF_BIT_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (half_tick)
    );

    mbt_parity_gen #(.DATA_W(DATA_W)) u_par (
        .data    (in_payload),
        .par_bit (par_calc)
    );

    assign tx_bit = (state == ST_PARITY) ? par_q : shreg[DATA_W-1];

    mbt_manchester u_man (
        .bit_val     (tx_bit),
        .second_half (half_ph),
        .level       (coded_lvl)
    );

    // command/status sync starts high, data sync starts low
    assign sync_lvl = (cnt < SPLIT_CNT) ? (kind == WT_CMD_STATUS)
                                        : (kind != WT_CMD_STATUS);

    // state register and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            half_ph <= 1'b0;
            shreg   <= '0;
            par_q   <= 1'b0;
            kind    <= WT_CMD_STATUS;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state   <= ST_SYNC;
                        cnt     <= '0;
                        half_ph <= 1'b0;
                        shreg   <= in_payload;
                        par_q   <= par_calc;
                        kind    <= word_kind_t'(in_is_data);
                    end
                end
                ST_SYNC: begin
                    if (half_tick) begin
                        if (cnt == SYNC_LAST) begin
                            state <= ST_DATA;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (half_tick) begin
                        half_ph <= ~half_ph;
                        if (half_ph) begin
                            shreg <= {shreg[DATA_W-2:0], 1'b0};
                            if (cnt == BIT_LAST) begin
                                state <= ST_PARITY;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_PARITY: begin
                    if (half_tick) begin
                        half_ph <= ~half_ph;
                        if (half_ph) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        busy     = 1'b1;
        line_en  = 1'b1;
        line_hi  = 1'b0;
        line_lo  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                busy     = 1'b0;
                line_en  = 1'b0;
            end
            ST_SYNC: begin
                line_hi = sync_lvl;
                line_lo = ~sync_lvl;
            end
            ST_DATA, ST_PARITY: begin
                line_hi = coded_lvl;
                line_lo = ~coded_lvl;
            end
            default: begin
                busy    = 1'b0;
                line_en = 1'b0;
            end
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/mbt_word_tx_chk.sv
module mbt_word_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic done,
    input logic line_hi,
    input logic line_lo,
    input logic line_en,
    input logic half_tick
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_en && !line_hi && !line_lo));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R3
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !half_tick) |=> ($stable(line_hi) && busy && line_en));

    // R7
    diff_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_en |-> (line_hi != line_lo));

    // R8
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && in_ready && $past(busy)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mbt_word_tx mbt_word_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .done      (done),
    .line_hi   (line_hi),
    .line_lo   (line_lo),
    .line_en   (line_en),
    .half_tick (half_tick)
);

// File: tb/mbt_word_tx_test.sv
`timescale 1ns/1ps
module mbt_word_tx_test;
    localparam int HB = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_payload = '0;
    logic        in_is_data = 1'b0;
    logic        busy;
    logic        done;
    logic        line_hi;
    logic        line_lo;
    logic        line_en;

    int checks = 0;
    int fails  = 0;
    int jpos   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mbt_word_tx #(.HALF_BIT_CYCLES(HB)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_payload (in_payload),
        .in_is_data (in_is_data),
        .busy       (busy),
        .done       (done),
        .line_hi    (line_hi),
        .line_lo    (line_lo),
        .line_en    (line_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_level(input logic [15:0] p, input logic d, input int k);
        int  m;
        logic v;
        if (k < 6) return (k < 3) ? ~d : d;
        m = k - 6;
        v = (m / 2 < 16) ? p[15 - m / 2] : ~(^p);
        return (m % 2 == 0) ? v : ~v;
    endfunction

    // caller stands at a negedge with the block ready
    task automatic start_word(input logic [15:0] p, input logic d);
        in_valid   = 1'b1;
        in_payload = p;
        in_is_data = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        jpos = 0;
        chk(busy && !in_ready, "R2", "busy/ready after accept",
            {30'd0, busy, in_ready}, 32'h2);
        chk(!done, "R8", "done at frame start", {31'd0, done}, 32'h0);
    endtask

    task automatic advance_to(input int target, input bit junk,
                              input logic [15:0] p, input logic d);
        while (jpos < target) begin
            @(negedge clk);
            jpos++;
            if (junk && jpos == 1) begin
                in_valid   = 1'b1;
                in_payload = ~p;
                in_is_data = ~d;
            end
            if (junk && jpos == 20 * HB) in_valid = 1'b0;
        end
    endtask

    // ends at the negedge of the done cycle
    task automatic check_frame(input logic [15:0] p, input logic d, input bit junk);
        for (int k = 0; k < 40; k++) begin
            logic e;
            string req;
            advance_to(k * HB + HB / 2, junk, p, d);
            e = exp_level(p, d, k);
            req = (k < 6) ? "R4" : ((k < 38) ? "R5" : "R6");
            if (junk) req = "R2";
            chk({line_en, line_hi, line_lo} == {1'b1, e, ~e}, req,
                $sformatf("slot %0d en/hi/lo (R7)", k),
                {29'd0, line_en, line_hi, line_lo}, {29'd0, 1'b1, e, ~e});
        end
        advance_to(40 * HB - 1, junk, p, d);
        chk(busy && line_en && !done, "R3", "last cycle of frame",
            {29'd0, busy, line_en, done}, 32'h6);
        advance_to(40 * HB, junk, p, d);
        chk(done && !busy && in_ready, "R8", "done cycle",
            {29'd0, done, busy, in_ready}, 32'h5);
        chk(!line_en && !line_hi && !line_lo, "R1", "lines quiet after frame",
            {29'd0, line_en, line_hi, line_lo}, 32'h0);
    endtask

    task automatic leave_done;
        @(negedge clk);
        chk(!done && !busy, "R8", "done one cycle wide",
            {30'd0, done, busy}, 32'h0);
    endtask

    task automatic test_reset;
        chk(!busy && in_ready && !done, "R1", "reset busy/ready/done",
            {29'd0, busy, in_ready, done}, 32'h2);
        chk(!line_en && !line_hi && !line_lo, "R1", "reset lines",
            {29'd0, line_en, line_hi, line_lo}, 32'h0);
    endtask

    task automatic test_word(input logic [15:0] p, input logic d);
        start_word(p, d);
        check_frame(p, d, 1'b0);
        leave_done();
    endtask

    task automatic test_ignore_busy;
        start_word(16'h1234, 1'b0);
        check_frame(16'h1234, 1'b0, 1'b1);
        leave_done();
        chk(in_ready && !busy, "R2", "junk not taken as a word",
            {30'd0, in_ready, busy}, 32'h2);
    endtask

    task automatic test_back_to_back;
        start_word(16'h0F0F, 1'b1);
        check_frame(16'h0F0F, 1'b1, 1'b0);
        start_word(16'h7001, 1'b0);
        check_frame(16'h7001, 1'b0, 1'b0);
        leave_done();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_word(16'hA5C3, 1'b0);
        test_word(16'h3C96, 1'b1);
        test_word(16'hFFFF, 1'b1);
        test_word(16'h0000, 1'b0);
        test_word(16'h8000, 1'b1);
        test_word(16'h0001, 1'b0);
        test_ignore_busy();
        test_back_to_back();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule